// File: doc/BRIEF.md
# Clock-Enable Generator for a Single-Clock Build

This block derives two slower timing references from one main clock without gating or switching any clock. Both references leave the block as one-cycle enable strobes in the main-clock domain. Logic that wants to run at the slower rate keeps the main clock and advances only in cycles where the strobe is high. The auxiliary strobe always counts rising edges of a slow free-running oscillator input, typically near 32 kHz. That input has no known phase relation to the main clock, so the block first resynchronizes it. The sub-main strobe counts either every main-clock cycle or the same oscillator edges, as software selects.

Two byte-wide control registers sit on a small peripheral bus. Software uses them to pick a power-of-two divide ratio for each strobe and the source of the sub-main strobe. When the processor requests its off state, the block does not stop the clock. It raises an idle indication that the processor's state machines use to park, while the clock and both strobes keep running.

Top module: `clken_gen`

## Requirements
- R1: While `rst` is high, and after it is released, both control registers read as zero. Zero means both ratios are /1 and the sub-main source is the main clock. `aux_en`, `sub_en` and `cpu_idle` are low during reset, and both divider counters restart from zero.
- R2: The auxiliary control register is the byte at byte address 0x0057, which is the upper lane (`bus_we[1]`, data bits [15:8]) of the 16-bit word at 0x0056. Its bits [5:4] hold the auxiliary ratio code, and every other bit of the byte reads as zero.
- R3: The sub-main control register is the byte at byte address 0x0058, which is the lower lane (`bus_we[0]`, data bits [7:0]). Bit 3 selects the source and bits [2:1] hold the ratio code. All other bits read as zero, and writing it leaves the auxiliary counter untouched.
- R4: Ratio codes 0, 1, 2 and 3 give one strobe per 1, 2, 4 and 8 source ticks. Writing a register's byte clears that divider's counter, so the first strobe after a write comes on the N-th source tick.
- R5: The oscillator input passes through a two-flop synchronizer and a rising-edge detector. Suppose it rises before main-clock edge k and stays high for at least two cycles. Then a /1 auxiliary strobe is high for exactly the one cycle after edge k+2.
- R6: With source bit 0, the sub-main divider ticks on every main-clock cycle. At ratio N, writing the register at edge w makes strobes appear after edges w+N, w+2N, and so on.
- R7: With source bit 1, the sub-main divider ticks on the same synchronized oscillator edges as the auxiliary divider.
- R8: `cpu_idle` follows `cpu_off` one main-clock cycle later. Both strobes continue unchanged while idle.
- R9: A read (`bus_en` high, `bus_we` zero) returns data one cycle later, with each register in its own lane and zero for any other address. A write to an unmapped word, or one whose byte enable misses a register's lane, changes no register.
- R10: `aux_en` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock; every register in the block runs on it |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Peripheral access strobe |
| bus_addr | input | ADDR_W (15) | Byte address of the access |
| bus_we | input | DATA_W/8 (2) | Byte-lane write enables; all zero means read |
| bus_wdata | input | DATA_W (16) | Write data |
| bus_rdata | output | DATA_W (16) | Registered read data |
| lf_clk_in | input | 1 | Slow oscillator, asynchronous to `clk` |
| cpu_off | input | 1 | Processor off-state request |
| aux_en | output | 1 | Auxiliary one-cycle enable strobe |
| sub_en | output | 1 | Sub-main one-cycle enable strobe |
| cpu_idle | output | 1 | Registered idle indication for the processor |

## Verification
A wrong counter value does not stay hidden. The bench pins each expected strobe to an exact main-clock cycle, so a counter that misses a clear on write, or a mask that is off by one bit, moves the strobe by at least one tick. That is one cycle in main-clock mode and one oscillator period in slow mode, and the shift shows up at the first strobe after the write. A synchronizer that is one stage too short or too long shifts every auxiliary strobe by one cycle against the cycle predicted from the driven edge. A lane or decode fault shows as a wrong value on the very next read-back.

// File: rtl/clken_pkg.sv
package clken_pkg;

  // ratio code width; the largest ratio is 2**(2**DIV_SEL_W - 1)
  localparam int DIV_SEL_W = 2;

  // field positions inside the two control bytes
  localparam int AUX_DIV_LSB = 4;
  localparam int SUB_SEL_BIT = 3;
  localparam int SUB_DIV_LSB = 1;

  typedef logic [DIV_SEL_W-1:0] div_sel_t;

  typedef struct packed {
    div_sel_t aux_div;
    logic     sub_sel_lf;
    div_sel_t sub_div;
  } clk_cfg_t;

endpackage

// File: rtl/clken_sync.sv
module clken_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic tick_o
);

  // STAGES synchronizer flops plus one history flop for the edge detect
  logic [STAGES:0] pipe_q;

  always_ff @(posedge clk) begin
    if (rst) pipe_q <= '0;
    else     pipe_q <= {pipe_q[STAGES-1:0], async_in};
  end

  assign tick_o = pipe_q[STAGES-1] & ~pipe_q[STAGES];

  // R5: a rising edge yields one isolated tick
  p_tick_gap_r5: assert property (@(posedge clk) disable iff (rst)
    tick_o |=> !tick_o);

endmodule

// File: rtl/clken_div.sv
module clken_div
  import clken_pkg::*;
#(
  parameter int SEL_W = DIV_SEL_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             tick,
  input  logic [SEL_W-1:0] div_sel,
  output logic             en_o
);

  localparam int CNT_W = (1 << SEL_W) - 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] mask;

  assign mask = ~({CNT_W{1'b1}} << div_sel);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      en_o  <= 1'b0;
    end else begin
      en_o <= tick && ((cnt_q & mask) == mask);
      if (clr)       cnt_q <= '0;
      else if (tick) cnt_q <= cnt_q + 1'b1;
    end
  end

  // R4: any ratio above one cannot strobe in back-to-back cycles
  p_div_gap_r4: assert property (@(posedge clk) disable iff (rst)
    (en_o && div_sel != '0) |=> !en_o);

endmodule

// File: rtl/clken_regs.sv
module clken_regs
  import clken_pkg::*;
#(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned DATA_W = 16,
  parameter logic [ADDR_W-1:0] AUX_ADDR = 'h57,
  parameter logic [ADDR_W-1:0] SUB_ADDR = 'h58
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bus_en,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [DATA_W/8-1:0]   bus_we,
  input  logic [DATA_W-1:0]     bus_wdata,
  output logic [DATA_W-1:0]     bus_rdata,
  output clk_cfg_t              cfg_o,
  output logic                  aux_clr,
  output logic                  sub_clr
);

  localparam int LANES    = DATA_W / 8;
  localparam int LANE_W   = (LANES > 1) ? $clog2(LANES) : 1;
  localparam int AUX_LANE = (LANES > 1) ? int'(AUX_ADDR[LANE_W-1:0]) : 0;
  localparam int SUB_LANE = (LANES > 1) ? int'(SUB_ADDR[LANE_W-1:0]) : 0;

  logic       aux_hit, sub_hit, rd_req;
  logic [7:0] aux_wbyte, sub_wbyte, aux_rbyte, sub_rbyte;
  logic [DATA_W-1:0] rdata_next;

  assign aux_hit = bus_en && (bus_addr[ADDR_W-1:LANE_W] == AUX_ADDR[ADDR_W-1:LANE_W]);
  assign sub_hit = bus_en && (bus_addr[ADDR_W-1:LANE_W] == SUB_ADDR[ADDR_W-1:LANE_W]);
  assign rd_req  = bus_en && (bus_we == '0);

  assign aux_wbyte = bus_wdata[8*AUX_LANE +: 8];
  assign sub_wbyte = bus_wdata[8*SUB_LANE +: 8];
  assign aux_clr   = aux_hit && bus_we[AUX_LANE];
  assign sub_clr   = sub_hit && bus_we[SUB_LANE];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_o <= '0;
    end else begin
      if (aux_clr) cfg_o.aux_div <= aux_wbyte[AUX_DIV_LSB +: DIV_SEL_W];
      if (sub_clr) begin
        cfg_o.sub_sel_lf <= sub_wbyte[SUB_SEL_BIT];
        cfg_o.sub_div    <= sub_wbyte[SUB_DIV_LSB +: DIV_SEL_W];
      end
    end
  end

  always_comb begin
    aux_rbyte = '0;
    aux_rbyte[AUX_DIV_LSB +: DIV_SEL_W] = cfg_o.aux_div;
    sub_rbyte = '0;
    sub_rbyte[SUB_SEL_BIT] = cfg_o.sub_sel_lf;
    sub_rbyte[SUB_DIV_LSB +: DIV_SEL_W] = cfg_o.sub_div;
    rdata_next = '0;
    if (aux_hit) rdata_next[8*AUX_LANE +: 8] = aux_rbyte;
    if (sub_hit) rdata_next[8*SUB_LANE +: 8] = rdata_next[8*SUB_LANE +: 8] | sub_rbyte;
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (rd_req) bus_rdata <= rdata_next;
    else             bus_rdata <= '0;
  end

  // R9: no write strobe, no register change
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !(bus_en && (bus_we != '0)) |=> $stable(cfg_o));

  // R9: reads of foreign words return zero
  p_unmapped_r9: assert property (@(posedge clk) disable iff (rst)
    (bus_en && bus_we == '0 &&
     bus_addr[ADDR_W-1:LANE_W] != AUX_ADDR[ADDR_W-1:LANE_W] &&
     bus_addr[ADDR_W-1:LANE_W] != SUB_ADDR[ADDR_W-1:LANE_W]) |=> bus_rdata == '0);

endmodule

// File: rtl/clken_gen.sv
module clken_gen
  import clken_pkg::*;
#(
  parameter int unsigned ADDR_W      = 15,
  parameter int unsigned DATA_W      = 16,
  parameter int          SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] AUX_ADDR = 'h57,
  parameter logic [ADDR_W-1:0] SUB_ADDR = 'h58
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_en,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W/8-1:0] bus_we,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic                lf_clk_in,
  input  logic                cpu_off,
  output logic                aux_en,
  output logic                sub_en,
  output logic                cpu_idle
);

  clk_cfg_t cfg;
  logic     aux_clr, sub_clr, lf_tick, sub_tick;

  clken_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .AUX_ADDR(AUX_ADDR), .SUB_ADDR(SUB_ADDR)
  ) regs_i (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cfg_o(cfg),
    .aux_clr(aux_clr), .sub_clr(sub_clr)
  );

  clken_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .async_in(lf_clk_in), .tick_o(lf_tick)
  );

  assign sub_tick = cfg.sub_sel_lf ? lf_tick : 1'b1;

  clken_div #(.SEL_W(DIV_SEL_W)) aux_div_i (
    .clk(clk), .rst(rst), .clr(aux_clr), .tick(lf_tick),
    .div_sel(cfg.aux_div), .en_o(aux_en)
  );

  clken_div #(.SEL_W(DIV_SEL_W)) sub_div_i (
    .clk(clk), .rst(rst), .clr(sub_clr), .tick(sub_tick),
    .div_sel(cfg.sub_div), .en_o(sub_en)
  );

  always_ff @(posedge clk) begin
    if (rst) cpu_idle <= 1'b0;
    else     cpu_idle <= cpu_off;
  end

  // R8: an off request is seen as idle one cycle later
  p_idle_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(cpu_off) |=> cpu_idle);

  // R10: auxiliary strobe is always a lone cycle
  p_aux_single_r10: assert property (@(posedge clk) disable iff (rst)
    aux_en |=> !aux_en);

  // R7: on a settled slow source the sub-main strobe is also a lone cycle
  p_sub_lf_gap_r7: assert property (@(posedge clk) disable iff (rst)
    (cfg.sub_sel_lf && $past(cfg.sub_sel_lf) && sub_en) |=> !sub_en);

endmodule

// File: tb/clken_gen_tb_top.sv
`timescale 1ns/1ps
module clken_gen_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_en = 1'b0;
  logic [14:0] bus_addr = '0;
  logic [1:0]  bus_we = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        lf_clk_in = 1'b0;
  logic        cpu_off = 1'b0;
  logic        aux_en, sub_en, cpu_idle;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit mon_aux = 0;
  bit mon_sub = 0;
  bit finished = 0;
  string aux_tag = "R5";
  string sub_tag = "R6";
  int exp_aux[$];
  int exp_sub[$];

  always #4 clk = ~clk;

  clken_gen dut_i (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .lf_clk_in(lf_clk_in),
    .cpu_off(cpu_off), .aux_en(aux_en), .sub_en(sub_en), .cpu_idle(cpu_idle)
  );

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s cycle=%0d actual=%0h expected=%0h", req, cyc, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // monitor: pops expected strobe cycles and compares 1 ns after each falling edge
  always begin
    @(negedge clk);
    #1;
    if (mon_aux) begin
      bit e;
      e = (exp_aux.size() != 0 && exp_aux[0] == cyc);
      if (e) void'(exp_aux.pop_front());
      check(aux_en == e, aux_tag, aux_en, e);
    end
    if (mon_sub) begin
      bit e;
      e = (exp_sub.size() != 0 && exp_sub[0] == cyc);
      if (e) void'(exp_sub.pop_front());
      check(sub_en == e, sub_tag, sub_en, e);
    end
  end

  task automatic bus_write(input logic [14:0] a, input logic [1:0] be,
                           input logic [15:0] d, output int w);
    @(negedge clk);
    bus_en = 1; bus_addr = a; bus_we = be; bus_wdata = d;
    @(negedge clk);
    w = cyc;
    bus_en = 0; bus_we = '0;
  endtask

  task automatic bus_read(input logic [14:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_en = 1; bus_addr = a; bus_we = '0;
    @(negedge clk);
    d = bus_rdata;
    bus_en = 0;
  endtask

  task automatic read_check(input logic [14:0] a, input logic [15:0] exp, input string req);
    logic [15:0] d;
    bus_read(a, d);
    check(d == exp, req, d, exp);
  endtask

  // driver: one oscillator rising edge; pushes the cycles in which strobes are due
  task automatic lf_rise(input bit aux_hit, input bit sub_hit);
    int c;
    @(negedge clk);
    lf_clk_in = 1;
    c = cyc;
    if (aux_hit) exp_aux.push_back(c + 3);
    if (sub_hit) exp_sub.push_back(c + 3);
    repeat (3) @(negedge clk);
    lf_clk_in = 0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    int w;
    // R1: reset state
    repeat (3) @(negedge clk);
    check(aux_en == 0, "R1", aux_en, 0);
    check(sub_en == 0, "R1", sub_en, 0);
    check(cpu_idle == 0, "R1", cpu_idle, 0);
    rst = 0;
    read_check(15'h0056, 16'h0000, "R1");
    read_check(15'h0058, 16'h0000, "R1");

    // R6 at /1: main-clock source strobes every cycle
    repeat (5) begin
      @(negedge clk);
      check(sub_en == 1, "R6", sub_en, 1);
    end

    // R5: /1 auxiliary strobe three edges after the driven rise
    aux_tag = "R5"; mon_aux = 1;
    repeat (3) lf_rise(1, 0);

    // R2 + R4: /4 on the auxiliary divider
    aux_tag = "R4";
    bus_write(15'h0056, 2'b10, 16'h2000, w);
    read_check(15'h0056, 16'h2000, "R2");
    repeat (2) begin
      lf_rise(0, 0); lf_rise(0, 0); lf_rise(0, 0); lf_rise(1, 0);
    end

    // R2: unused bits read zero; R4: /8
    bus_write(15'h0056, 2'b10, 16'hFFFF, w);
    read_check(15'h0056, 16'h3000, "R2");
    repeat (7) lf_rise(0, 0);
    lf_rise(1, 0);

    // R6: main-clock source at /8
    bus_write(15'h0058, 2'b01, 16'h0006, w);
    exp_sub.push_back(w + 8);
    exp_sub.push_back(w + 16);
    exp_sub.push_back(w + 24);
    sub_tag = "R6";
    @(negedge clk); mon_sub = 1;
    while (cyc < w + 26) @(negedge clk);
    mon_sub = 0;
    check(exp_sub.size() == 0, "R6", exp_sub.size(), 0);

    // R3: field layout and zero bits
    bus_write(15'h0058, 2'b01, 16'h00FF, w);
    read_check(15'h0058, 16'h000E, "R3");
    bus_write(15'h0058, 2'b01, 16'h000A, w);
    read_check(15'h0058, 16'h000A, "R3");

    // R7: slow source at /2; aux counter (/8) continues from 0 untouched (R3)
    sub_tag = "R7"; aux_tag = "R3";
    @(negedge clk); mon_sub = 1;
    lf_rise(0, 0); lf_rise(0, 1); lf_rise(0, 0); lf_rise(0, 1);

    // R8: idle follows request; strobes continue
    aux_tag = "R8"; sub_tag = "R8";
    @(negedge clk);
    cpu_off = 1;
    @(negedge clk);
    check(cpu_idle == 1, "R8", cpu_idle, 1);
    lf_rise(0, 0); lf_rise(0, 1); lf_rise(0, 0); lf_rise(1, 1);
    check(cpu_idle == 1, "R8", cpu_idle, 1);
    cpu_off = 0;
    @(negedge clk);
    check(cpu_idle == 0, "R8", cpu_idle, 0);

    // R9: ignored writes and unmapped reads
    bus_write(15'h0056, 2'b01, 16'hFFFF, w);
    read_check(15'h0056, 16'h3000, "R9");
    bus_write(15'h005A, 2'b11, 16'hFFFF, w);
    read_check(15'h0056, 16'h3000, "R9");
    read_check(15'h0058, 16'h000A, "R9");
    read_check(15'h005A, 16'h0000, "R9");
    bus_write(15'h0058, 2'b10, 16'hFFFF, w);
    read_check(15'h0058, 16'h000A, "R9");

    // R1: reset from a configured state
    mon_aux = 0; mon_sub = 0;
    check(exp_aux.size() == 0, "R4", exp_aux.size(), 0);
    check(exp_sub.size() == 0, "R7", exp_sub.size(), 0);
    @(negedge clk); rst = 1;
    repeat (2) @(negedge clk);
    check(aux_en == 0 && sub_en == 0, "R1", {aux_en, sub_en}, 0);
    rst = 0;
    read_check(15'h0056, 16'h0000, "R1");
    read_check(15'h0058, 16'h0000, "R1");
    repeat (2) @(negedge clk);
    report();
  end

endmodule